// File: doc/BRIEF.md
# Serial Audio Frame Receiver

This block takes stereo PCM audio from a three-wire serial link made of a bit clock, a data line and a channel-select line. It runs on a system clock that is much faster than the bit clock. It passes all three wires through a synchronizer and works out the rising edges of the bit clock from the synchronized copy. Each data bit is taken at a bit-clock rising edge, most significant bit first. A change on the channel-select line marks the start of a new word.

The receiver needs no host setup to tell narrow frames (16 bit clocks per channel) from wide frames (32 bit clocks per channel). It counts the bit clocks between channel-select changes. Two static configuration inputs adapt it to related formats:

- One chooses which level of channel-select means the left channel.
- The other chooses whether the first bit of a word comes one bit clock after the channel-select change or on the same bit clock.

At the end of each good stereo frame the block presents both words, left-justified in full-width registers, together with the detected frame width. It marks them with a one-cycle strobe. A frame whose channel lengths are not legal is dropped, and a status output shows that lock has been lost.

Top module: `serial_audio_rx`

## Requirements
- R1: Data and channel-select are taken only at rising edges of the bit clock. A level on the data line between rising edges has no effect on the received words.
- R2: Words are received most significant bit first and are shown left-justified in 32-bit outputs. For a narrow frame, bits 31..16 hold the 16 received bits and bits 15..0 read zero.
- R3: With `cfgWsInvert` = 0, channel-select low means left and high means right. With `cfgWsInvert` = 1 the meanings swap.
- R4: With `cfgNoDelay` = 0, the first bit of a word is the bit taken one bit clock after the channel-select change. With `cfgNoDelay` = 1, it is the bit taken on the first rising edge that sees the changed channel-select level.
- R5: The number of bit clocks between two channel-select changes decides the frame width: 16 gives a narrow frame (`wideMode` = 0) and 32 gives a wide frame (`wideMode` = 1). `wideMode` is updated together with each published frame.
- R6: A frame is dropped, with no strobe, in two cases: any channel length other than 16 or 32, or left and right lengths that differ. Such a frame clears `lockOk`. `lockOk` is set again by the next published frame, and it is high whenever the strobe is high.
- R7: `frameValid` pulses high for exactly one system clock for each good frame, once the right word has ended. The sample outputs and `wideMode` hold their values between pulses.
- R8: While reset is asserted, both sample outputs are zero, and `frameValid`, `wideMode` and `lockOk` are low.
- R9: The first channel-select change after reset only starts bit counting. A right word that was not preceded by a fully received left word is never published.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sckIn | input | 1 | Serial bit clock (asynchronous) |
| wsIn | input | 1 | Channel-select line (asynchronous) |
| sdIn | input | 1 | Serial data line (asynchronous) |
| cfgWsInvert | input | 1 | 1: left channel while channel-select is high |
| cfgNoDelay | input | 1 | 1: first bit comes with the channel-select change, with no one-bit delay |
| leftOut | output | 32 | Left word, left-justified |
| rightOut | output | 32 | Right word, left-justified |
| frameValid | output | 1 | One-cycle strobe when a new frame is shown |
| wideMode | output | 1 | 1: last frame had 32 bit clocks per channel |
| lockOk | output | 1 | Last completed channel lengths were legal and matching |

## Verification
The assertions check, on every cycle, properties that hold whatever the audio content is:

- the strobe is a single-cycle pulse;
- lock is high whenever the strobe is high;
- the outputs and the width flag stay still between strobes;
- the low half of both words is zero in narrow frames;
- the outputs are cleared during reset.

Only the bench scenarios can show that the bit values are right. That includes the most-significant-first ordering under both delay settings, the left/right swap from the polarity input, and correct width detection when the format changes. They also show that illegal or mismatched channel lengths produce no strobe, and that a stream joined in the middle of a frame is not published.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // Strobes passed from control to datapath on each bit event
  typedef struct packed {
    logic shiftEn;   // a bit-clock rising edge was seen: shift in data
    logic useCur;    // word ends with the bit taken this event (delayed format)
    logic capLeft;   // a left word has just ended: hold it
    logic publish;   // a right word ended and the frame is good: present it
    logic wide;      // the ending word was wide
  } sarStrobe_t;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic wsIn,
  input  logic sdIn,
  output logic bitEvt,
  output logic wsS,
  output logic sdS
);

  localparam int LANES = 3;

  logic [SYNC_STAGES-1:0][LANES-1:0] stage;
  logic sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage   <= '0;
      sckPrev <= 1'b0;
    end else begin
      stage[0] <= {sckIn, wsIn, sdIn};
      for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
      sckPrev <= stage[SYNC_STAGES-1][2];
    end
  end

  assign bitEvt = stage[SYNC_STAGES-1][2] & ~sckPrev;
  assign wsS    = stage[SYNC_STAGES-1][1];
  assign sdS    = stage[SYNC_STAGES-1][0];

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int NARROW_BITS = 16,
  parameter int WIDE_BITS   = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEvt,
  input  logic       wsS,
  input  logic       cfgWsInvert,
  input  logic       cfgNoDelay,
  output sarStrobe_t strobe,
  output logic       lockOk
);

  localparam int CNT_W = $clog2(WIDE_BITS) + 2;
  localparam logic [CNT_W-1:0] CNT_MAX    = '1;
  localparam logic [CNT_W-1:0] LEN_NARROW = CNT_W'(NARROW_BITS);
  localparam logic [CNT_W-1:0] LEN_WIDE   = CNT_W'(WIDE_BITS);

  logic             wsPrev, havePrev, started;
  logic [CNT_W-1:0] bitCnt;
  logic             leftOk, leftWide;

  logic wsEdge, lenNarrow, lenWide, lenGood, doneIsLeft, pairOk;

  always_comb begin
    wsEdge     = bitEvt && havePrev && (wsS != wsPrev);
    lenNarrow  = (bitCnt == LEN_NARROW);
    lenWide    = (bitCnt == LEN_WIDE);
    lenGood    = lenNarrow || lenWide;
    doneIsLeft = (wsPrev == cfgWsInvert);
    pairOk     = lenGood && leftOk && (leftWide == lenWide);

    strobe.shiftEn = bitEvt;
    strobe.useCur  = !cfgNoDelay;
    strobe.wide    = lenWide;
    strobe.capLeft = wsEdge && started && doneIsLeft;
    strobe.publish = wsEdge && started && !doneIsLeft && pairOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wsPrev   <= 1'b0;
      havePrev <= 1'b0;
      started  <= 1'b0;
      bitCnt   <= '0;
      leftOk   <= 1'b0;
      leftWide <= 1'b0;
      lockOk   <= 1'b0;
    end else if (bitEvt) begin
      wsPrev   <= wsS;
      havePrev <= 1'b1;
      if (wsEdge) begin
        started <= 1'b1;
        bitCnt  <= CNT_W'(1);
        if (started) begin
          if (doneIsLeft) begin
            leftOk   <= lenGood;
            leftWide <= lenWide;
            if (!lenGood) lockOk <= 1'b0;
          end else begin
            leftOk <= 1'b0;
            lockOk <= pairOk;
          end
        end
      end else if (started && bitCnt != CNT_MAX) begin
        bitCnt <= bitCnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/sar_dpath.sv
module sar_dpath
  import sar_pkg::*;
#(
  parameter int NARROW_BITS = 16,
  parameter int WIDE_BITS   = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sarStrobe_t           strobe,
  input  logic                 sdS,
  output logic [WIDE_BITS-1:0] leftOut,
  output logic [WIDE_BITS-1:0] rightOut,
  output logic                 frameValid,
  output logic                 wideMode
);

  localparam int PAD_BITS = WIDE_BITS - NARROW_BITS;

  logic [WIDE_BITS-1:0] shiftReg, leftHold;
  logic [WIDE_BITS-1:0] wordFull, wordJust;

  always_comb begin
    wordFull = strobe.useCur ? {shiftReg[WIDE_BITS-2:0], sdS} : shiftReg;
    wordJust = strobe.wide ? wordFull
                           : {wordFull[NARROW_BITS-1:0], {PAD_BITS{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      leftHold   <= '0;
      leftOut    <= '0;
      rightOut   <= '0;
      frameValid <= 1'b0;
      wideMode   <= 1'b0;
    end else begin
      frameValid <= 1'b0;
      if (strobe.shiftEn) shiftReg <= {shiftReg[WIDE_BITS-2:0], sdS};
      if (strobe.capLeft) leftHold <= wordJust;
      if (strobe.publish) begin
        leftOut    <= leftHold;
        rightOut   <= wordJust;
        wideMode   <= strobe.wide;
        frameValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sar_pkg::*;
#(
  parameter int NARROW_BITS = 16,
  parameter int WIDE_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sckIn,
  input  logic                 wsIn,
  input  logic                 sdIn,
  input  logic                 cfgWsInvert,
  input  logic                 cfgNoDelay,
  output logic [WIDE_BITS-1:0] leftOut,
  output logic [WIDE_BITS-1:0] rightOut,
  output logic                 frameValid,
  output logic                 wideMode,
  output logic                 lockOk
);

  logic       bitEvt, wsS, sdS;
  sarStrobe_t strobe;

  sar_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .wsIn(wsIn), .sdIn(sdIn),
    .bitEvt(bitEvt), .wsS(wsS), .sdS(sdS)
  );

  sar_ctrl #(.NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .bitEvt(bitEvt), .wsS(wsS),
    .cfgWsInvert(cfgWsInvert), .cfgNoDelay(cfgNoDelay),
    .strobe(strobe), .lockOk(lockOk)
  );

  sar_dpath #(.NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdS(sdS),
    .leftOut(leftOut), .rightOut(rightOut),
    .frameValid(frameValid), .wideMode(wideMode)
  );

endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
  parameter int NARROW_BITS = 16,
  parameter int WIDE_BITS   = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [WIDE_BITS-1:0] leftOut,
  input logic [WIDE_BITS-1:0] rightOut,
  input logic                 frameValid,
  input logic                 wideMode,
  input logic                 lockOk
);

  localparam int PAD_BITS = WIDE_BITS - NARROW_BITS;

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> !frameValid);

  p_hold_between_r7: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> ($stable(leftOut) && $stable(rightOut) && $stable(wideMode)));

  p_lock_on_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |-> lockOk);

  p_narrow_pad_r2: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !wideMode) |->
      (leftOut[PAD_BITS-1:0] == '0 && rightOut[PAD_BITS-1:0] == '0));

  p_reset_clear_r8: assert property (@(posedge clk)
    !rstN |-> (leftOut == '0 && rightOut == '0 && !frameValid && !wideMode && !lockOk));

endmodule

bind serial_audio_rx sar_checker #(.NARROW_BITS(NARROW_BITS), .WIDE_BITS(WIDE_BITS)) uChk (
  .clk(clk), .rstN(rstN), .leftOut(leftOut), .rightOut(rightOut),
  .frameValid(frameValid), .wideMode(wideMode), .lockOk(lockOk)
);

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;

  typedef struct packed {
    logic [31:0] l;
    logic [31:0] r;
    logic        w;
  } expItem_t;

  localparam int HALF_SYS = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sckIn = 1'b0, wsIn = 1'b0, sdIn = 1'b0;
  logic cfgWsInvert = 1'b0, cfgNoDelay = 1'b0;
  logic [31:0] leftOut, rightOut;
  logic frameValid, wideMode, lockOk;

  int checks = 0;
  int fails = 0;
  expItem_t expQ[$];
  logic carry = 1'b0;
  logic prevValid = 1'b0;

  always #2 clk = ~clk;

  serial_audio_rx u0 (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .wsIn(wsIn), .sdIn(sdIn),
    .cfgWsInvert(cfgWsInvert), .cfgNoDelay(cfgNoDelay),
    .leftOut(leftOut), .rightOut(rightOut),
    .frameValid(frameValid), .wideMode(wideMode), .lockOk(lockOk)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] justify(input logic [31:0] w, input int len);
    return (len == 32) ? w : {w[15:0], 16'h0};
  endfunction

  // One bit clock: data and channel-select change while the clock is low.
  // sdIn toggles mid-high phase to show levels between rises are ignored (R1).
  task automatic bitClk(input logic wsv, input logic bitv);
    @(negedge clk);
    sckIn = 1'b0; wsIn = wsv; sdIn = bitv;
    repeat (HALF_SYS) @(negedge clk);
    sckIn = 1'b1;
    repeat (2) @(negedge clk);
    sdIn = ~bitv;
    repeat (HALF_SYS - 2) @(negedge clk);
  endtask

  task automatic sendHalf(input logic wsv, input logic [31:0] w, input int len, input logic noDel);
    for (int i = 0; i < len; i++) begin
      logic b;
      if (noDel) b = w[len-1-i];
      else b = (i == 0) ? carry : w[len-i];
      bitClk(wsv, b);
    end
    carry = w[0];
  endtask

  task automatic sendFrame(input int len, input logic [31:0] l, input logic [31:0] r, input bit expect_);
    if (expect_) expQ.push_back('{l: justify(l, len), r: justify(r, len), w: (len == 32)});
    sendHalf(cfgWsInvert, l, len, cfgNoDelay);
    sendHalf(~cfgWsInvert, r, len, cfgNoDelay);
  endtask

  task automatic restart(input logic inv, input logic noDel);
    @(negedge clk);
    rstN = 1'b0;
    cfgWsInvert = inv; cfgNoDelay = noDel;
    sckIn = 1'b0; wsIn = ~inv; sdIn = 1'b0;
    repeat (4) @(negedge clk);
    check(leftOut == 0 && rightOut == 0, "R8 outputs clear", leftOut, 0);
    check(!frameValid && !wideMode && !lockOk, "R8 flags clear",
          {29'h0, frameValid, wideMode, lockOk}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    sendHalf(~inv, 32'h0, 4, noDel);  // idle on the right level before the stream
  endtask

  task automatic finishStream(string req);
    sendHalf(cfgWsInvert, 32'h0, 4, cfgNoDelay);  // closing edge ends the last right word
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  // Monitor: compare each strobe against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (frameValid && prevValid) check(0, "R7 strobe longer than one cycle", 2, 1);
      if (frameValid) begin
        if (expQ.size() == 0) begin
          check(0, "R6 unexpected frame", leftOut, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(leftOut == e.l, "R2/R3/R4 left word", leftOut, e.l);
          check(rightOut == e.r, "R2/R3/R4 right word", rightOut, e.r);
          check(wideMode == e.w, "R5 width flag", {31'h0, wideMode}, {31'h0, e.w});
          check(lockOk, "R6 lock with strobe", {31'h0, lockOk}, 1);
        end
      end
    end
    prevValid <= frameValid;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R8 reset state, then wide frames with the one-bit delay (R1, R2, R4, R5, R7)
    restart(1'b0, 1'b0);
    sendFrame(32, 32'h8123_4567, 32'hFEDC_BA98, 1);
    sendFrame(32, 32'h0000_0001, 32'h8000_0000, 1);
    sendFrame(32, 32'hA5A5_5A5A, 32'h0F0F_F0F0, 1);
    finishStream("R7 all wide frames delivered");

    // Narrow frames then a back-to-back switch to wide (R2, R5)
    restart(1'b0, 1'b0);
    sendFrame(16, 32'h0000_8001, 32'h0000_7FFE, 1);
    sendFrame(16, 32'h0000_1234, 32'h0000_ABCD, 1);
    sendFrame(32, 32'h1357_9BDF, 32'h2468_ACE0, 1);
    sendFrame(16, 32'h0000_C3C3, 32'h0000_0001, 1);
    finishStream("R5 mixed-width frames delivered");

    // Inverted channel-select polarity (R3)
    restart(1'b1, 1'b0);
    sendFrame(32, 32'h1111_2222, 32'h3333_4444, 1);
    sendFrame(16, 32'h0000_00FF, 32'h0000_FF00, 1);
    finishStream("R3 inverted polarity frames delivered");

    // No one-bit delay (R4)
    restart(1'b0, 1'b1);
    sendFrame(32, 32'hDEAD_BEEF, 32'h0123_4567, 1);
    sendFrame(16, 32'h0000_8000, 32'h0000_0001, 1);
    sendFrame(32, 32'h8000_0001, 32'h7FFF_FFFE, 1);
    finishStream("R4 undelayed frames delivered");

    // Joined mid-frame (R9), bad and mismatched lengths (R6)
    restart(1'b0, 1'b0);
    sendHalf(1'b0, 32'hFFFF_FFFF, 10, 1'b0);          // tail of a left word
    sendHalf(1'b1, 32'hCAFE_F00D, 32, 1'b0);          // lone right word: not published
    sendFrame(32, 32'h0BAD_CAFE, 32'h600D_F00D, 1);
    sendHalf(1'b0, 32'h00AB_CDEF, 24, 1'b0);          // illegal left length
    sendHalf(1'b1, 32'h1234_5678, 32, 1'b0);
    check(lockOk == 1'b0, "R6 lock cleared by illegal length", {31'h0, lockOk}, 0);
    sendHalf(1'b0, 32'h0000_1234, 16, 1'b0);          // narrow left, wide right
    sendHalf(1'b1, 32'h8765_4321, 32, 1'b0);
    check(lockOk == 1'b0, "R6 lock low after mismatched lengths", {31'h0, lockOk}, 0);
    sendFrame(32, 32'h4242_4242, 32'h2424_2424, 1);
    finishStream("R6/R9 only good frames delivered");
    check(lockOk == 1'b1, "R6 lock regained", {31'h0, lockOk}, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule